// File: doc/BRIEF.md
# Channel-Parallel 2x2 Max Pooling Unit

This block halves the height and width of a signed feature map held in on-chip memory. For every channel it reads each non-overlapping 2x2 window, at stride 2, and writes the largest sample of that window to an output memory. Eight channels share one memory word, so eight lanes compute eight window maxima side by side from a single stream of reads.

Software-visible sizing is not fixed at build time. A start pulse captures the row count, column count and channel count, each up to a limit set by parameters. The unit then walks the map with one read request per cycle and asserts a one-cycle completion pulse when the last result has been written. If a row or column count is odd, the last row or column is left out of the result. Samples and results are signed 16-bit values by default.

Top module: `maxpool2x2_unit`

## Requirements
- R1: Each written lane value is the signed maximum of the four samples of its 2x2 window in that lane's channel. Lane i occupies bits [16i+15:16i] of a memory word and carries channel 8g+i of channel group g.
- R2: The output has floor(rows/2) rows and floor(cols/2) columns for each channel. A trailing odd row or column is never read into any result.
- R3: Reads run in the order channel group, output row, output column, window row, window column. The input word address is g*rows*cols + r*cols + c. Results are written to addresses 0, 1, 2 and onward in the same window order, one step per write.
- R4: The running maximum restarts from the most negative value (-32768) at every window. A window whose four samples are all -32768 yields -32768. A large value in one window never carries into the next window.
- R5: The lane write mask marks exactly those lanes whose channel index 8g+i is below the channel count. When the channel count is not a multiple of eight, the unused lanes of the last group are never written.
- R6: Row, column and channel counts are captured on a start pulse that arrives while the unit is idle. A start pulse or a change of the size inputs during a run has no effect on that run.
- R7: The completion output is high for exactly one cycle, one cycle after the final result write. A start with fewer than two rows, fewer than two columns or zero channels performs no reads and no writes and still completes.
- R8: After reset, and while reset is held, there are no read requests, no writes and no completion pulse. A reset during a run abandons it, and the next start runs normally.
- R9: One read is issued on every cycle of a run, so a map with W windows per channel group set takes 4W reads. Memory data is taken one cycle after its request. Completion is seen 4W+3 cycles after the clock edge that captured start; this also holds for W = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a pass; ignored while a pass runs |
| cfg_rows | input | $clog2(MAX_M+1) | Input row count, captured on start |
| cfg_cols | input | $clog2(MAX_N+1) | Input column count, captured on start |
| cfg_chans | input | $clog2(MAX_H+1) | Channel count, captured on start |
| rd_en | output | 1 | Read request to the input memory |
| rd_addr | output | IA_W | Input word address |
| rd_data | input | LANES*DW | Input word, valid the cycle after the request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | OA_W | Result word address |
| wr_mask | output | LANES | Per-lane write enable |
| wr_data | output | LANES*DW | Result word, one signed maximum per lane |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is applied before the first start and that the input memory answers every request in the next cycle. They also assume that start is raised only when the previous pass has delivered its completion pulse or has been cut off by reset, so the write addresses of one pass always follow each other. The bench keeps to these rules. It always waits for completion or resets before the next start, and it models the memory as a one-cycle registered array. The only start it raises during a pass is the one that R6 says must be ignored.

// File: rtl/maxpool_pkg.sv
package maxpool_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mp_state_e;

endpackage

// File: rtl/maxpool_lane.sv
module maxpool_lane #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic                 smp_first,
    input  logic signed [DW-1:0] smp,
    output logic signed [DW-1:0] max_now
);
    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] acc_d, acc_q;
    logic signed [DW-1:0] base;

    always_comb begin
        base    = smp_first ? MOST_NEG : acc_q;
        // strict compare: an equal sample leaves the running value in place
        max_now = (smp > base) ? smp : base;
        acc_d   = smp_valid ? max_now : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= MOST_NEG;
        else     acc_q <= acc_d;
    end
endmodule

// File: rtl/maxpool_addr_seq.sv
module maxpool_addr_seq
    import maxpool_pkg::*;
#(
    parameter  int MAX_M   = 256,
    parameter  int MAX_N   = 256,
    parameter  int MAX_H   = 512,
    parameter  int LANES   = 8,
    localparam int MW      = $clog2(MAX_M + 1),
    localparam int NW      = $clog2(MAX_N + 1),
    localparam int HW      = $clog2(MAX_H + 1),
    localparam int MAX_GRP = (MAX_H + LANES - 1) / LANES,
    localparam int GW      = $clog2(MAX_GRP + 1),
    localparam int IA_W    = $clog2(MAX_GRP * MAX_M * MAX_N),
    localparam int OA_W    = $clog2(MAX_GRP * (MAX_M / 2) * (MAX_N / 2))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MW-1:0]    cfg_rows,
    input  logic [NW-1:0]    cfg_cols,
    input  logic [HW-1:0]    cfg_chans,
    output logic             rd_en,
    output logic [IA_W-1:0]  rd_addr,
    output logic             tag_first,
    output logic             tag_last,
    output logic             tag_fin,
    output logic [LANES-1:0] tag_mask,
    output logic [OA_W-1:0]  tag_oaddr
);
    localparam int LANE_SH = $clog2(LANES);

    typedef struct packed {
        mp_state_e        state;
        logic [MW-1:0]    rows;
        logic [NW-1:0]    cols;
        logic [HW-1:0]    chans;
        logic [MW-1:0]    out_r;
        logic [NW-1:0]    out_c;
        logic [GW-1:0]    ngrp;
        logic [GW-1:0]    grp;
        logic [MW-1:0]    orow;
        logic [NW-1:0]    ocol;
        logic [1:0]       k;
        logic [IA_W-1:0]  plane;
        logic [OA_W-1:0]  oaddr;
        logic             rd_en;
        logic [IA_W-1:0]  rd_addr;
        logic             first;
        logic             last;
        logic             fin;
        logic [LANES-1:0] mask;
        logic [OA_W-1:0]  tag_oaddr;
    } seq_t;

    seq_t d, q;

    logic [IA_W-1:0]  row_i, col_i, plane_step;
    logic [HW:0]      chan_i;
    logic [LANES-1:0] mask_c;
    logic             last_col, last_row, last_grp, empty_cfg;

    always_comb begin
        d        = q;
        d.rd_en  = 1'b0;
        d.first  = 1'b0;
        d.last   = 1'b0;
        d.fin    = 1'b0;

        row_i      = IA_W'({q.orow, 1'b0}) + IA_W'(q.k[1]);
        col_i      = IA_W'({q.ocol, 1'b0}) + IA_W'(q.k[0]);
        plane_step = IA_W'(q.rows) * IA_W'(q.cols);

        chan_i = '0;
        for (int i = 0; i < LANES; i++) begin
            chan_i    = ((HW+1)'(q.grp) << LANE_SH) + (HW+1)'(i);
            mask_c[i] = chan_i < (HW+1)'(q.chans);
        end

        last_col  = (q.ocol == q.out_c - NW'(1));
        last_row  = (q.orow == q.out_r - MW'(1));
        last_grp  = (q.grp  == q.ngrp  - GW'(1));
        empty_cfg = (cfg_rows < MW'(2)) || (cfg_cols < NW'(2)) || (cfg_chans == '0);

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.rows  = cfg_rows;
                    d.cols  = cfg_cols;
                    d.chans = cfg_chans;
                    d.out_r = cfg_rows >> 1;
                    d.out_c = cfg_cols >> 1;
                    d.ngrp  = GW'(((HW+1)'(cfg_chans) + (HW+1)'(LANES - 1)) >> LANE_SH);
                    d.grp   = '0;
                    d.orow  = '0;
                    d.ocol  = '0;
                    d.k     = '0;
                    d.plane = '0;
                    d.oaddr = '0;
                    if (empty_cfg) d.fin   = 1'b1;
                    else           d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                d.rd_en     = 1'b1;
                d.rd_addr   = q.plane + row_i * IA_W'(q.cols) + col_i;
                d.first     = (q.k == 2'd0);
                d.last      = (q.k == 2'd3);
                d.mask      = mask_c;
                d.tag_oaddr = q.oaddr;
                d.k         = q.k + 2'd1;
                if (q.k == 2'd3) begin
                    d.oaddr = q.oaddr + OA_W'(1);
                    if (last_col) begin
                        d.ocol = '0;
                        if (last_row) begin
                            d.orow  = '0;
                            d.grp   = q.grp + GW'(1);
                            d.plane = q.plane + plane_step;
                            if (last_grp) begin
                                d.fin   = 1'b1;
                                d.state = ST_IDLE;
                            end
                        end else begin
                            d.orow = q.orow + MW'(1);
                        end
                    end else begin
                        d.ocol = q.ocol + NW'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rd_en     = q.rd_en;
    assign rd_addr   = q.rd_addr;
    assign tag_first = q.first;
    assign tag_last  = q.last;
    assign tag_fin   = q.fin;
    assign tag_mask  = q.mask;
    assign tag_oaddr = q.tag_oaddr;
endmodule

// File: rtl/maxpool2x2_unit.sv
module maxpool2x2_unit
    import maxpool_pkg::*;
#(
    parameter  int DW      = 16,
    parameter  int LANES   = 8,
    parameter  int MAX_M   = 256,
    parameter  int MAX_N   = 256,
    parameter  int MAX_H   = 512,
    localparam int MW      = $clog2(MAX_M + 1),
    localparam int NW      = $clog2(MAX_N + 1),
    localparam int HW      = $clog2(MAX_H + 1),
    localparam int MAX_GRP = (MAX_H + LANES - 1) / LANES,
    localparam int IA_W    = $clog2(MAX_GRP * MAX_M * MAX_N),
    localparam int OA_W    = $clog2(MAX_GRP * (MAX_M / 2) * (MAX_N / 2)),
    localparam int WW      = LANES * DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MW-1:0]    cfg_rows,
    input  logic [NW-1:0]    cfg_cols,
    input  logic [HW-1:0]    cfg_chans,
    output logic             rd_en,
    output logic [IA_W-1:0]  rd_addr,
    input  logic [WW-1:0]    rd_data,
    output logic             wr_en,
    output logic [OA_W-1:0]  wr_addr,
    output logic [LANES-1:0] wr_mask,
    output logic [WW-1:0]    wr_data,
    output logic             done
);
    typedef struct packed {
        logic             valid;
        logic             first;
        logic             last;
        logic             fin;
        logic [LANES-1:0] mask;
        logic [OA_W-1:0]  oaddr;
    } smp_stage_t;

    typedef struct packed {
        logic             wr_en;
        logic [OA_W-1:0]  addr;
        logic [LANES-1:0] mask;
        logic [WW-1:0]    data;
        logic             fin;
        logic             done;
    } out_stage_t;

    logic             g_first, g_last, g_fin;
    logic [LANES-1:0] g_mask;
    logic [OA_W-1:0]  g_oaddr;
    logic [WW-1:0]    lane_max;

    smp_stage_t s1_d, s1_q;
    out_stage_t s2_d, s2_q;

    maxpool_addr_seq #(
        .MAX_M (MAX_M),
        .MAX_N (MAX_N),
        .MAX_H (MAX_H),
        .LANES (LANES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_rows  (cfg_rows),
        .cfg_cols  (cfg_cols),
        .cfg_chans (cfg_chans),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .tag_first (g_first),
        .tag_last  (g_last),
        .tag_fin   (g_fin),
        .tag_mask  (g_mask),
        .tag_oaddr (g_oaddr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        maxpool_lane #(.DW(DW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (s1_q.valid),
            .smp_first (s1_q.first),
            .smp       (rd_data[i*DW +: DW]),
            .max_now   (lane_max[i*DW +: DW])
        );
    end

    always_comb begin
        // stage 1 lines up the request tags with the returning memory word
        s1_d.valid = rd_en;
        s1_d.first = g_first;
        s1_d.last  = g_last;
        s1_d.fin   = g_fin;
        s1_d.mask  = g_mask;
        s1_d.oaddr = g_oaddr;

        // stage 2 registers the finished window and the completion chain
        s2_d.wr_en = s1_q.valid && s1_q.last;
        s2_d.addr  = s1_q.oaddr;
        s2_d.mask  = (s1_q.valid && s1_q.last) ? s1_q.mask : '0;
        s2_d.data  = (s1_q.valid && s1_q.last) ? lane_max : s2_q.data;
        s2_d.fin   = s1_q.fin;
        s2_d.done  = s2_q.fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign wr_en   = s2_q.wr_en;
    assign wr_addr = s2_q.addr;
    assign wr_mask = s2_q.mask;
    assign wr_data = s2_q.data;
    assign done    = s2_q.done;
endmodule

// File: rtl/maxpool_checker.sv
module maxpool_checker #(
    parameter int LANES = 8,
    parameter int OA_W  = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             wr_en,
    input logic [OA_W-1:0]  wr_addr,
    input logic [LANES-1:0] wr_mask,
    input logic             done
);
    logic            seen_q;
    logic [OA_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || done) seen_q <= 1'b0;
        else if (wr_en)  seen_q <= 1'b1;
        if (wr_en) last_q <= wr_addr;
    end

    // R3: consecutive result writes of one pass step the address by one
    p_wr_order_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seen_q) |-> (wr_addr == last_q + OA_W'(1)));

    // R5: a write enables a non-empty run of lanes starting at lane 0
    p_mask_low_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_mask != '0) && ((wr_mask & (wr_mask + LANES'(1))) == '0)));

    // R7: completion lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: every result write follows a read request two cycles earlier
    p_wr_lat_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rd_en, 2));

    // R8: the cycle after a reset edge is quiet on all outputs
    p_quiet_reset_r8: assert property (@(posedge clk)
        rst |=> (!rd_en && !wr_en && !done));
endmodule

bind maxpool2x2_unit maxpool_checker #(
    .LANES (LANES),
    .OA_W  (OA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask),
    .done    (done)
);

// File: tb/tb_maxpool2x2_unit.sv
`timescale 1ns/1ps
module tb_maxpool2x2_unit;
    localparam int DW      = 16;
    localparam int LANES   = 8;
    localparam int MAX_M   = 16;
    localparam int MAX_N   = 16;
    localparam int MAX_H   = 24;
    localparam int MW      = $clog2(MAX_M + 1);
    localparam int NW      = $clog2(MAX_N + 1);
    localparam int HW      = $clog2(MAX_H + 1);
    localparam int MAX_GRP = (MAX_H + LANES - 1) / LANES;
    localparam int IA_W    = $clog2(MAX_GRP * MAX_M * MAX_N);
    localparam int OA_W    = $clog2(MAX_GRP * (MAX_M / 2) * (MAX_N / 2));
    localparam int IDEPTH  = MAX_GRP * MAX_M * MAX_N;
    localparam int ODEPTH  = MAX_GRP * (MAX_M / 2) * (MAX_N / 2);
    localparam int WW      = LANES * DW;
    localparam int LIM     = 4000;

    // rows, cols, chans, pattern, expected windows over all groups
    localparam int NV = 10;
    localparam int VEC [NV][5] = '{
        '{ 4,  4,  8, 0,   4},
        '{16, 16, 24, 0, 192},
        '{ 5,  7,  8, 2,   6},
        '{ 6,  6, 13, 1,  18},
        '{ 9,  4,  3, 3,   8},
        '{ 2,  2,  1, 4,   1},
        '{ 1,  8,  8, 0,   0},
        '{ 8,  8,  0, 0,   0},
        '{ 7,  3, 20, 0,   9},
        '{16, 15, 17, 4, 168}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [MW-1:0]    cfg_rows = '0;
    logic [NW-1:0]    cfg_cols = '0;
    logic [HW-1:0]    cfg_chans = '0;
    logic             rd_en;
    logic [IA_W-1:0]  rd_addr;
    logic [WW-1:0]    rd_data = '0;
    logic             wr_en;
    logic [OA_W-1:0]  wr_addr;
    logic [LANES-1:0] wr_mask;
    logic [WW-1:0]    wr_data;
    logic             done;

    logic [WW-1:0]    imem [IDEPTH];
    logic [WW-1:0]    omem [ODEPTH];
    logic [LANES-1:0] owr  [ODEPTH];

    int n_chk = 0, n_fail = 0, cyc_total = 0;
    int rd_idx = 0, rd_bad = 0, wr_cnt = 0, wr_bad = 0, exp_wr = 0;
    int cm = 2, cn = 2;

    always #5 clk = ~clk;

    maxpool2x2_unit #(
        .DW (DW), .LANES (LANES), .MAX_M (MAX_M), .MAX_N (MAX_N), .MAX_H (MAX_H)
    ) dut (
        .clk (clk), .rst (rst), .start (start),
        .cfg_rows (cfg_rows), .cfg_cols (cfg_cols), .cfg_chans (cfg_chans),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_mask (wr_mask), .wr_data (wr_data),
        .done (done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_rd_addr(input int idx);
        int k, w, oc, orw, g, om, on;
        om  = cm / 2;
        on  = cn / 2;
        k   = idx % 4;
        w   = idx / 4;
        oc  = w % on;
        orw = (w / on) % om;
        g   = w / (on * om);
        return g * cm * cn + (2 * orw + k / 2) * cn + 2 * oc + k % 2;
    endfunction

    function automatic logic signed [15:0] pix(input int pat, input int g, input int l,
                                               input int r, input int c, input int m,
                                               input int n, input int h);
        int ch, v;
        ch = g * 8 + l;
        if (ch >= h || r >= (m / 2) * 2 || c >= (n / 2) * 2) return 16'sh7FFF;
        case (pat)
            0: v = (r * 1237 + c * 7919 + ch * 4513 + r * c * 31) ^ (ch << 9);
            1: v = -32768;
            2: v = r * n + c + ch;
            3: v = -(r * n + c) - 100 * ch;
            default: v = ((r + c + ch) % 2 == 1) ? 1000 - ch : -1000 - ch;
        endcase
        return 16'(v);
    endfunction

    function automatic int win_max(input int pat, input int g, input int l, input int orw,
                                   input int oc, input int m, input int n, input int h);
        int best, s;
        best = -32768;
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++) begin
                s = int'(pix(pat, g, l, 2 * orw + i, 2 * oc + j, m, n, h));
                if (s > best) best = s;
            end
        return best;
    endfunction

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        if (rd_en) begin
            rd_data <= (int'(rd_addr) < IDEPTH) ? imem[rd_addr] : '0;
            if (int'(rd_addr) != exp_rd_addr(rd_idx)) rd_bad++;
            rd_idx++;
        end
        if (wr_en) begin
            if (int'(wr_addr) != exp_wr) wr_bad++;
            exp_wr++;
            wr_cnt++;
            if (int'(wr_addr) < ODEPTH) begin
                for (int l = 0; l < LANES; l++)
                    if (wr_mask[l]) omem[wr_addr][l*DW +: DW] <= wr_data[l*DW +: DW];
                owr[wr_addr] <= owr[wr_addr] | wr_mask;
            end
        end
    end

    task automatic run_cfg(input int m, input int n, input int h, input int pat,
                           input int expw, input int poke, input string tag);
        int lat, bad, maskbad, om, on, grp;
        om  = m / 2;
        on  = n / 2;
        grp = (h + LANES - 1) / LANES;
        for (int a = 0; a < ODEPTH; a++) begin
            omem[a] = '0;
            owr[a]  = '0;
        end
        for (int g = 0; g < MAX_GRP; g++)
            for (int r = 0; r < MAX_M; r++)
                for (int c = 0; c < MAX_N; c++)
                    if (g * m * n + r * n + c < IDEPTH && r < m && c < n)
                        for (int l = 0; l < LANES; l++)
                            imem[g * m * n + r * n + c][l*DW +: DW] = pix(pat, g, l, r, c, m, n, h);
        cm = (m < 2) ? 2 : m;
        cn = (n < 2) ? 2 : n;
        rd_idx = 0; rd_bad = 0; wr_cnt = 0; wr_bad = 0; exp_wr = 0;
        cfg_rows  = MW'(m);
        cfg_cols  = NW'(n);
        cfg_chans = HW'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < LIM) begin
            @(negedge clk);
            lat++;
            if (poke != 0 && lat == poke) begin
                start     = 1'b1;
                cfg_rows  = MW'(2);
                cfg_cols  = NW'(2);
                cfg_chans = HW'(1);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        // R9: completion latency and one read per cycle
        chk(lat == 4 * expw + 3, "R9", {tag, " done latency"}, lat, 4 * expw + 3);
        chk(rd_idx == 4 * expw, "R9", {tag, " read count"}, rd_idx, 4 * expw);
        @(negedge clk);
        // R7: single-cycle completion
        chk(done == 1'b0, "R7", {tag, " done width"}, int'(done), 0);
        // R2: floored output size
        chk(wr_cnt == expw, "R2", {tag, " write count"}, wr_cnt, expw);
        // R3: read and write ordering
        chk(rd_bad == 0 && wr_bad == 0, "R3", {tag, " order errors"}, rd_bad + wr_bad, 0);
        bad = 0;
        maskbad = 0;
        for (int w = 0; w < expw; w++) begin
            int g, rem, orw, oc;
            logic [LANES-1:0] em;
            g   = w / (om * on);
            rem = w % (om * on);
            orw = rem / on;
            oc  = rem % on;
            for (int l = 0; l < LANES; l++) em[l] = (g * 8 + l < h);
            if (owr[w] != em) maskbad++;
            for (int l = 0; l < LANES; l++)
                if (g * 8 + l < h)
                    if (int'($signed(omem[w][l*DW +: DW])) != win_max(pat, g, l, orw, oc, m, n, h))
                        bad++;
        end
        // R1 and R4: window maxima per lane, fresh start each window
        chk(bad == 0, (pat == 1 || pat == 3) ? "R4" : "R1", {tag, " value mismatches"}, bad, 0);
        // R5: written lanes follow the channel count
        chk(maskbad == 0, "R5", {tag, " lane mask errors"}, maskbad, 0);
        if (grp == 0) chk(wr_cnt == 0, "R7", {tag, " empty pass writes"}, wr_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: quiet while reset is held
        chk(!rd_en && !wr_en && !done, "R8", "outputs in reset",
            int'(rd_en) + int'(wr_en) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R8", "outputs after reset",
            int'(rd_en) + int'(wr_en) + int'(done), 0);

        for (int v = 0; v < NV; v++)
            run_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0,
                    $sformatf("vec%0d", v));

        // R6: start and new sizes during a pass are ignored
        run_cfg(16, 16, 24, 0, 192, 10, "busy start");

        // R8: reset in the middle of a pass, then a clean pass
        cfg_rows  = MW'(16);
        cfg_cols  = NW'(16);
        cfg_chans = HW'(24);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rd_en && !wr_en && !done, "R8", "outputs after mid-pass reset",
            int'(rd_en) + int'(wr_en) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        run_cfg(4, 4, 8, 3, 4, 0, "after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule